// File: doc/BRIEF.md
# Remap Setup Decoder

This block carries out the setup step of an indexed element-remapping command in one clock. A single command gives a five-bit remap mask, a mode bit, the parameters of a new shape and the current remap state. The block returns write strobes and write data for four shape registers, along with the next remap state. That state has five two-bit selectors, a five-bit enable vector and a persistence flag. The shape registers and the state register sit outside the block. The caller feeds the current state back in and stores what comes out.

The mode bit picks how the mask is read. With the mode bit clear, the mask is a set of operand roles. The block clears all four shapes and the whole state. It then visits the set mask bits from lowest to highest and gives each one the next free shape slot. The slot counter wraps after slot 3. With the mode bit set, the mask is a packed pair that names one role and one shape. The block writes only that shape and updates only that role's selector and enable bit.

A shape word holds three fields. The X size is decoded from an off-by-one operand, the Y size is passed through as given, and the index base register number is the operand field multiplied by four. All outputs are registered and change only on the cycle after a valid strobe.

Top module: `remap_setup_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, all outputs are zero until the first valid strobe.
- R2: Every shape word written has three fields. Bits [5:0] hold the X size, equal to the 5-bit X operand plus one, so the range is 1..32. Bits [11:6] hold the Y size, copied from its input. Bits [18:12] hold the index base field shifted left by two. Shape k occupies bits [19k+18:19k] of the data output.
- R3: When the mode bit is 0, all four shape write strobes are set and the persistence flag is cleared. Any shape that is not handed a slot is written with all-zero data.
- R4: When the mode bit is 0, mask bits are visited from bit 0 to bit 4. Each set bit takes the next slot, starting at 0, and its selector is set to that slot. The enable vector equals the mask. The selectors of clear mask bits are zero. Selector j occupies bits [2j+1:2j]: j=0,1,2 are the three inputs and j=3,4 are the two outputs.
- R5: When the mode bit is 0 and all five mask bits are set, the slot counter wraps. Selectors 0 and 4 both hold 0, and selectors 1, 2 and 3 hold 1, 2 and 3.
- R6: When the mode bit is 1, mask[4:2] names selector code c and mask[1:0] names shape s. If c is 0..4, only shape s is strobed, with the new shape word. Selector c becomes s, enable bit c is set and the persistence flag is set.
- R7: When the mode bit is 1 and c is 0..4, every other selector and enable bit takes its value from the current-state inputs.
- R8: When the mode bit is 1 and c is 5, 6 or 7, no shape is strobed. The state outputs become exactly the current-state inputs, persistence flag included.
- R9: On a cycle after one with no valid strobe, all shape strobes and shape data are zero, and the state outputs keep their previous values.
- R10: When the mode bit is 0 and the mask is zero, all four shapes are written with zero data, and all selectors and enables are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Command strobe |
| mm_i | input | 1 | Mask mode: 0 walks the set bits, 1 treats the mask as a selector/shape pair |
| mask_i | input | 5 | Remap mask |
| xdim_enc_i | input | 5 | X size minus one |
| ydim_i | input | 6 | Y size, supplied already decoded |
| idx_base_i | input | 5 | Index base register field |
| cur_sel_i | input | 10 | Current five two-bit selectors |
| cur_en_i | input | 5 | Current enable vector |
| cur_persist_i | input | 1 | Current persistence flag |
| shape_we_o | output | 4 | Shape write strobes, one per shape |
| shape_data_o | output | 76 | Four 19-bit shape words |
| sel_o | output | 10 | Next selectors |
| en_o | output | 5 | Next enable vector |
| persist_o | output | 1 | Next persistence flag |

## Verification
A faulty slot counter in the walking mode shows up at the ports in the very next cycle. The selectors repeat or skip slot numbers, and the set of strobed shapes that carry live data no longer matches the number of mask bits. A wrong selector-code decode in the packed mode either strobes the wrong shape or corrupts a selector that should have been kept, and this is also visible one cycle after the strobe. A state register that drifts while idle appears on the first cycle with no command, so the reference model is compared against every output on every clock.

// File: rtl/remap_setup_pkg.sv
package remap_setup_pkg;
  localparam int NUM_SEL    = 5;
  localparam int NUM_SHAPE  = 4;
  localparam int SEL_W      = $clog2(NUM_SHAPE);
  localparam int CODE_W     = NUM_SEL - SEL_W;
  localparam int DIM_ENC_W  = 5;
  localparam int DIM_W      = DIM_ENC_W + 1;
  localparam int BASE_FLD_W = 5;
  localparam int BASE_SHIFT = 2;
  localparam int BASE_W     = BASE_FLD_W + BASE_SHIFT;
  localparam int SHAPE_W    = BASE_W + 2 * DIM_W;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [DIM_W-1:0]  ydim;
    logic [DIM_W-1:0]  xdim;
  } shape_t;

  typedef logic [SEL_W-1:0] slot_t;
endpackage

// File: rtl/remap_shape_fmt.sv
module remap_shape_fmt
  import remap_setup_pkg::*;
(
  input  logic [DIM_ENC_W-1:0]  xdim_enc_i,
  input  logic [DIM_W-1:0]      ydim_i,
  input  logic [BASE_FLD_W-1:0] idx_base_i,
  output shape_t                shape_o
);
  always_comb begin
    shape_o.xdim = {1'b0, xdim_enc_i} + DIM_W'(1);
    shape_o.ydim = ydim_i;
    shape_o.base = {idx_base_i, {BASE_SHIFT{1'b0}}};
  end
endmodule

// File: rtl/remap_walk.sv
module remap_walk
  import remap_setup_pkg::*;
(
  input  logic [NUM_SEL-1:0]            mask_i,
  output logic [NUM_SEL-1:0][SEL_W-1:0] sel_o,
  output logic [NUM_SHAPE-1:0]          load_o
);
  slot_t slot;

  // slot width equals log2 of shape count, so increment wraps modulo NUM_SHAPE
  always_comb begin
    slot   = '0;
    sel_o  = '0;
    load_o = '0;
    for (int b = 0; b < NUM_SEL; b++) begin
      if (mask_i[b]) begin
        sel_o[b]     = slot;
        load_o[slot] = 1'b1;
        slot         = slot + slot_t'(1);
      end
    end
  end

  always_comb begin
    if ($countones(mask_i) >= NUM_SHAPE)
      assert_walk_full_R5: assert (load_o == '1);
    else
      assert_walk_slots_R4: assert ($countones(load_o) == $countones(mask_i));
  end
endmodule

// File: rtl/remap_pick.sv
module remap_pick
  import remap_setup_pkg::*;
(
  input  logic [NUM_SEL-1:0] mask_i,
  output logic               hit_o,
  output logic [NUM_SEL-1:0] which_o,
  output slot_t              slot_o
);
  localparam logic [CODE_W-1:0] CODE_LIM = CODE_W'(NUM_SEL);

  logic [CODE_W-1:0] code;

  assign code   = mask_i[NUM_SEL-1:SEL_W];
  assign slot_o = mask_i[SEL_W-1:0];
  assign hit_o  = code < CODE_LIM;

  for (genvar j = 0; j < NUM_SEL; j++) begin : g_dec
    assign which_o[j] = hit_o && (code == CODE_W'(j));
  end

  always_comb begin
    assert_pick_onehot_R6: assert ($onehot0(which_o));
    if (hit_o) assert_pick_hit_R8: assert (which_o != '0);
  end
endmodule

// File: rtl/remap_setup_ctrl.sv
module remap_setup_ctrl
  import remap_setup_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         valid_i,
  input  logic                         mm_i,
  input  logic [NUM_SEL-1:0]           mask_i,
  input  logic [DIM_ENC_W-1:0]         xdim_enc_i,
  input  logic [DIM_W-1:0]             ydim_i,
  input  logic [BASE_FLD_W-1:0]        idx_base_i,
  input  logic [NUM_SEL*SEL_W-1:0]     cur_sel_i,
  input  logic [NUM_SEL-1:0]           cur_en_i,
  input  logic                         cur_persist_i,
  output logic [NUM_SHAPE-1:0]         shape_we_o,
  output logic [NUM_SHAPE*SHAPE_W-1:0] shape_data_o,
  output logic [NUM_SEL*SEL_W-1:0]     sel_o,
  output logic [NUM_SEL-1:0]           en_o,
  output logic                         persist_o
);
  shape_t                         fmt_shape;
  logic [NUM_SEL-1:0][SEL_W-1:0]  walk_sel;
  logic [NUM_SHAPE-1:0]           walk_load;
  logic                           pick_hit;
  logic [NUM_SEL-1:0]             pick_which;
  slot_t                          pick_slot;
  logic [NUM_SEL-1:0][SEL_W-1:0]  cur_sel;

  logic [NUM_SHAPE-1:0]           nxt_we;
  shape_t [NUM_SHAPE-1:0]         nxt_data;
  logic [NUM_SEL-1:0][SEL_W-1:0]  nxt_sel;
  logic [NUM_SEL-1:0]             nxt_en;
  logic                           nxt_persist;

  logic [NUM_SHAPE-1:0]           we_q;
  shape_t [NUM_SHAPE-1:0]         data_q;
  logic [NUM_SEL-1:0][SEL_W-1:0]  sel_q;
  logic [NUM_SEL-1:0]             en_q;
  logic                           persist_q;
  logic                           armed_q;

  assign cur_sel = cur_sel_i;

  remap_shape_fmt u_fmt (
    .xdim_enc_i (xdim_enc_i),
    .ydim_i     (ydim_i),
    .idx_base_i (idx_base_i),
    .shape_o    (fmt_shape)
  );

  remap_walk u_walk (
    .mask_i (mask_i),
    .sel_o  (walk_sel),
    .load_o (walk_load)
  );

  remap_pick u_pick (
    .mask_i  (mask_i),
    .hit_o   (pick_hit),
    .which_o (pick_which),
    .slot_o  (pick_slot)
  );

  always_comb begin
    nxt_we      = '0;
    nxt_data    = '0;
    nxt_sel     = cur_sel;
    nxt_en      = cur_en_i;
    nxt_persist = cur_persist_i;
    if (!mm_i) begin
      nxt_we      = '1;
      nxt_sel     = walk_sel;
      nxt_en      = mask_i;
      nxt_persist = 1'b0;
      for (int k = 0; k < NUM_SHAPE; k++)
        if (walk_load[k]) nxt_data[k] = fmt_shape;
    end else if (pick_hit) begin
      nxt_we[pick_slot]   = 1'b1;
      nxt_data[pick_slot] = fmt_shape;
      nxt_en              = cur_en_i | pick_which;
      nxt_persist         = 1'b1;
      for (int j = 0; j < NUM_SEL; j++)
        if (pick_which[j]) nxt_sel[j] = pick_slot;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q      <= '0;
      data_q    <= '0;
      sel_q     <= '0;
      en_q      <= '0;
      persist_q <= 1'b0;
      armed_q   <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      if (valid_i) begin
        we_q      <= nxt_we;
        data_q    <= nxt_data;
        sel_q     <= nxt_sel;
        en_q      <= nxt_en;
        persist_q <= nxt_persist;
      end else begin
        we_q   <= '0;
        data_q <= '0;
      end
    end
  end

  assign shape_we_o   = we_q;
  assign shape_data_o = data_q;
  assign sel_o        = sel_q;
  assign en_o         = en_q;
  assign persist_o    = persist_q;

  assert_we_needs_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && shape_we_o != '0) |-> $past(valid_i));

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !$past(valid_i)) |-> ($stable(sel_o) && $stable(en_o) && $stable(persist_o)));

  assert_walk_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(valid_i && !mm_i)) |-> (shape_we_o == '1 && !persist_o));

  assert_walk_enable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(valid_i && !mm_i)) |-> (en_o == $past(mask_i)));

  assert_pick_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(valid_i && mm_i)) |-> ($countones(shape_we_o) <= 1));

  assert_pick_keep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(valid_i && mm_i)) |-> ((en_o & $past(cur_en_i)) == $past(cur_en_i)));
endmodule

// File: tb/sim_remap_setup_ctrl.sv
module sim_remap_setup_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        mm = 1'b0;
  logic [4:0]  mask = '0;
  logic [4:0]  xenc = '0;
  logic [5:0]  ydim = '0;
  logic [4:0]  base = '0;
  logic [9:0]  cur_sel = '0;
  logic [4:0]  cur_en = '0;
  logic        cur_p = 1'b0;
  logic [3:0]  we;
  logic [75:0] data;
  logic [9:0]  sel;
  logic [4:0]  en;
  logic        persist;

  logic [3:0]  e_we;
  logic [75:0] e_data;
  logic [9:0]  e_sel;
  logic [4:0]  e_en;
  logic        e_p;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  remap_setup_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .mm_i(mm), .mask_i(mask),
    .xdim_enc_i(xenc), .ydim_i(ydim), .idx_base_i(base), .cur_sel_i(cur_sel),
    .cur_en_i(cur_en), .cur_persist_i(cur_p), .shape_we_o(we), .shape_data_o(data),
    .sel_o(sel), .en_o(en), .persist_o(persist)
  );

  function automatic logic [18:0] word_of(input logic [4:0] xe, input logic [5:0] yd, input logic [4:0] bf);
    int w;
    w = ((int'(bf) * 4) << 12) | (int'(yd) << 6) | (int'(xe) + 1);
    return w[18:0];
  endfunction

  // behavioural reference: computes the expected registered outputs of one command
  task automatic model(input logic v);
    logic [18:0] w;
    int slot;
    int code;
    int s;
    w = word_of(xenc, ydim, base);
    e_we = '0;
    e_data = '0;
    if (!v) return;
    if (!mm) begin
      e_we = 4'hF;
      e_sel = '0;
      e_en = mask;
      e_p = 1'b0;
      slot = 0;
      for (int b = 0; b < 5; b++) begin
        if (mask[b]) begin
          e_sel[2*b +: 2] = slot[1:0];
          e_data[19*slot +: 19] = w;
          slot = (slot + 1) % 4;
        end
      end
    end else begin
      code = int'(mask[4:2]);
      s = int'(mask[1:0]);
      e_sel = cur_sel;
      e_en = cur_en;
      e_p = cur_p;
      if (code < 5) begin
        e_we[s] = 1'b1;
        e_data[19*s +: 19] = w;
        e_sel[2*code +: 2] = s[1:0];
        e_en[code] = 1'b1;
        e_p = 1'b1;
      end
    end
  endtask

  task automatic chk(input string tag, input string what, input logic [75:0] act, input logic [75:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "we", 76'(we), 76'(e_we));
    chk(tag, "data", data, e_data);
    chk(tag, "sel", 76'(sel), 76'(e_sel));
    chk(tag, "en", 76'(en), 76'(e_en));
    chk(tag, "persist", 76'(persist), 76'(e_p));
  endtask

  task automatic apply(input string tag, input logic v, input logic m, input logic [4:0] mk,
                       input logic [4:0] xe, input logic [5:0] yd, input logic [4:0] bf,
                       input logic [9:0] cs, input logic [4:0] ce, input logic cp);
    valid = v; mm = m; mask = mk; xenc = xe; ydim = yd; base = bf;
    cur_sel = cs; cur_en = ce; cur_p = cp;
    model(v);
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0;
    check_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    e_we = '0; e_data = '0; e_sel = '0; e_en = '0; e_p = 1'b0;
    valid = 1'b1; mm = 1'b1; mask = 5'b01110;
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    valid = 1'b0;
    @(negedge clk);
    check_all("R1");

    // R4 R2: walk mask 0b00110 -> mi1=0 mi2=1, shapes 0,1 loaded
    apply("R4", 1, 0, 5'b00110, 5'd2, 6'd3, 5'd5, 10'h3FF, 5'h1F, 1);
    chk("R2", "shape0", 76'(data[18:0]), 76'({7'd20, 6'd3, 6'd3}));
    chk("R4", "sel", 76'(sel), 76'(10'b00_00_01_00_00));
    apply("R5", 1, 0, 5'b11111, 5'd31, 6'd32, 5'd31, 10'h000, 5'h00, 0);
    chk("R5", "sel", 76'(sel), 76'(10'b00_11_10_01_00));
    chk("R2", "xmax", 76'(data[5:0]), 76'(6'd32));
    apply("R10", 1, 0, 5'b00000, 5'd7, 6'd7, 5'd7, 10'h2AA, 5'h15, 1);
    apply("R3", 1, 0, 5'b10101, 5'd0, 6'd1, 5'd1, 10'h155, 5'h0A, 1);
    apply("R9", 0, 0, 5'b11111, 5'd9, 6'd9, 5'd9, 10'h000, 5'h00, 0);
    apply("R9", 0, 1, 5'b00001, 5'd9, 6'd9, 5'd9, 10'h3FF, 5'h1F, 1);
    // R6 R7: code 3 shape 2
    apply("R6", 1, 1, 5'b01110, 5'd4, 6'd5, 5'd6, 10'b01_00_11_10_01, 5'b10001, 0);
    chk("R7", "sel", 76'(sel), 76'(10'b01_10_11_10_01));
    apply("R7", 1, 1, 5'b00011, 5'd1, 6'd2, 5'd3, 10'h2D8, 5'b00110, 1);
    apply("R6", 1, 1, 5'b10000, 5'd1, 6'd2, 5'd3, 10'h0FF, 5'b00000, 0);
    apply("R8", 1, 1, 5'b10110, 5'd1, 6'd2, 5'd3, 10'h1B3, 5'b01011, 1);
    apply("R8", 1, 1, 5'b11111, 5'd1, 6'd2, 5'd3, 10'h24C, 5'b10100, 0);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom();
      apply(r[0] ? (r[1] ? "R6" : "R4") : "R9", r[2] | r[3], r[1], r[8:4], r[13:9], r[19:14],
            r[24:20], {r[31:25], r[2:0]}, r[29:25], r[30]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule